// File: doc/BRIEF.md
# DRAM Controller Event Counter Block

This block sits next to a DRAM controller and tallies what the controller does. The controller presents a vector of single-cycle event lines and two strobes, one per completed DRAM read and one per completed DRAM write. Software programs and reads the block through a plain 64-bit register bus. The bus has a write strobe, an address and write data, and read data that follows the address in the same cycle.

Eight programmable counters each hold a configuration word. Its top bit arms the counter, and the remaining bits form a selection mask over the event lines. A counter advances by one in any cycle in which it is armed, a measurement session is open, and at least one selected line is high. A single mask bit picks one event. A group of adjacent bits picks a family of events, such as one event per rank. Sessions are opened and closed by writes to a start and an end register, and only while the block is in manual mode. Opening a fresh session zeroes all programmable counts.

Two dedicated counters track DRAM reads and writes. They do not depend on session state, and each has its own enable bit and its own clear strobe. Every count is CNT_W bits wide and wraps to zero. Bit CNT_W of each value read-back is a sticky wrap flag.

Top module: `dram_perf_mon`

## Requirements
- R1: After reset every mapped register reads zero: the mode, start, end-status, configuration, counter value and dedicated-counter registers.
- R2: A configuration word written at 0x8040+8n reads back unchanged. When its bit 63 is set and a session is open, counter n (value at 0x8080+8n) gains exactly one in each cycle where the AND of config bits [62:0] with the event lines is non-zero, however many of those bits match.
- R3: A programmable counter whose config bit 63 is clear never advances, even when its mask matches active events.
- R4: Writing bit 0 to 0x8028 opens a session only when mode bit 0 at 0x8020 is 1. Otherwise the write is ignored. While a session is open, 0x8028 reads back with bit 1 set.
- R5: Writing bit 0 to 0x8030 closes the open session. Programmable counts then hold their values, and 0x8038 reads back bit 0 set until the next session opens.
- R6: Opening a session from the idle state zeroes every programmable count and its wrap flag, and clears the end status.
- R7: A count advancing from 2^CNT_W−1 becomes 0 and sets its wrap flag. The wrap flag is bit CNT_W of the read-back and stays set while counting continues.
- R8: The enable register at 0x80C0 arms the write counter with bit 0 and the read counter with bit 1. An armed counter gains one per strobe regardless of session state. An unarmed counter holds its value. Values read at 0x80D0 (writes) and 0x80D8 (reads).
- R9: Writing 0x80C8 with bit 0 or bit 1 set zeroes the write or read counter and its wrap flag. The clear beats a strobe in the same cycle, and 0x80C8 itself reads zero.
- R10: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 64 | Register write data |
| bus_rdata | output | 64 | Register read data for bus_addr |
| evt_lines | input | EVT_W | Per-cycle controller event lines |
| dram_rd_strobe | input | 1 | One pulse per DRAM read |
| dram_wr_strobe | input | 1 | One pulse per DRAM write |

## Verification
A sweep drives each event line alone, then an all-lines pattern and an idle pattern, against counters programmed with single-bit masks, a four-bit rank mask, a two-bit mask spread across the ID range, and an unarmed mask. This separates correct mask selection from miscounting when several bits match in one cycle, and from counting while disarmed. A long run of one event pushes a counter through its wrap point to expose the flag. Ending and restarting a session shows the hold behaviour and the zeroing. The dedicated counters receive strobes with one or both enables set, outside a session, and in the same cycle as a clear, which shows enable independence and clear priority.

// File: rtl/dram_perf_mon.sv
module dram_perf_mon #(
  parameter int NUM_CNT = 8,
  parameter int CNT_W   = 48,
  parameter int ADDR_W  = 16,
  parameter int EVT_W   = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic [EVT_W-1:0]  evt_lines,
  input  logic              dram_rd_strobe,
  input  logic              dram_wr_strobe
);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(16'h8020);
  localparam logic [ADDR_W-1:0] A_START = ADDR_W'(16'h8028);
  localparam logic [ADDR_W-1:0] A_END   = ADDR_W'(16'h8030);
  localparam logic [ADDR_W-1:0] A_ENDST = ADDR_W'(16'h8038);
  localparam int                A_CFG   = 'h8040;
  localparam int                A_VAL   = 'h8080;
  localparam logic [ADDR_W-1:0] A_FREN  = ADDR_W'(16'h80C0);
  localparam logic [ADDR_W-1:0] A_FCLR  = ADDR_W'(16'h80C8);
  localparam logic [ADDR_W-1:0] A_WRV   = ADDR_W'(16'h80D0);
  localparam logic [ADDR_W-1:0] A_RDV   = ADDR_W'(16'h80D8);

  logic              mode_q, active_q, ended_q;
  logic [1:0]        fr_en_q;
  logic [CNT_W-1:0]  rd_val_q, wr_val_q;
  logic              rd_ovf_q, wr_ovf_q;
  logic [63:0]       cfg_q    [NUM_CNT];
  logic [CNT_W-1:0]  pc_val_q [NUM_CNT];
  logic              pc_ovf_q [NUM_CNT];

  wire hit_start = bus_wr && bus_addr == A_START && bus_wdata[0];
  wire hit_end   = bus_wr && bus_addr == A_END && bus_wdata[0];
  wire sess_clr  = hit_start && mode_q && !active_q;
  wire clr_wr    = bus_wr && bus_addr == A_FCLR && bus_wdata[0];
  wire clr_rd    = bus_wr && bus_addr == A_FCLR && bus_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      active_q <= 1'b0;
      ended_q  <= 1'b0;
      fr_en_q  <= '0;
    end else begin
      if (bus_wr && bus_addr == A_MODE) mode_q <= bus_wdata[0];
      if (bus_wr && bus_addr == A_FREN) fr_en_q <= bus_wdata[1:0];
      if (sess_clr) begin
        active_q <= 1'b1;
        ended_q  <= 1'b0;
      end else if (hit_end && active_q) begin
        active_q <= 1'b0;
        ended_q  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_val_q <= '0;
      rd_ovf_q <= 1'b0;
    end else if (clr_rd) begin
      rd_val_q <= '0;
      rd_ovf_q <= 1'b0;
    end else if (fr_en_q[1] && dram_rd_strobe) begin
      rd_val_q <= rd_val_q + 1'b1;
      if (&rd_val_q) rd_ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_val_q <= '0;
      wr_ovf_q <= 1'b0;
    end else if (clr_wr) begin
      wr_val_q <= '0;
      wr_ovf_q <= 1'b0;
    end else if (fr_en_q[0] && dram_wr_strobe) begin
      wr_val_q <= wr_val_q + 1'b1;
      if (&wr_val_q) wr_ovf_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_pc
    wire cfg_hit = bus_wr && bus_addr == ADDR_W'(A_CFG + 8 * i);
    wire bump    = active_q && cfg_q[i][63] && |(cfg_q[i][EVT_W-1:0] & evt_lines);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cfg_q[i] <= '0;
      else if (cfg_hit) cfg_q[i] <= bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_val_q[i] <= '0;
        pc_ovf_q[i] <= 1'b0;
      end else if (sess_clr) begin
        pc_val_q[i] <= '0;
        pc_ovf_q[i] <= 1'b0;
      end else if (bump) begin
        pc_val_q[i] <= pc_val_q[i] + 1'b1;
        if (&pc_val_q[i]) pc_ovf_q[i] <= 1'b1;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_MODE:  bus_rdata = {63'b0, mode_q};
      A_START: bus_rdata = {62'b0, active_q, 1'b0};
      A_ENDST: bus_rdata = {63'b0, ended_q};
      A_FREN:  bus_rdata = {62'b0, fr_en_q};
      A_WRV:   bus_rdata = 64'({wr_ovf_q, wr_val_q});
      A_RDV:   bus_rdata = 64'({rd_ovf_q, rd_val_q});
      default: ;
    endcase
    for (int i = 0; i < NUM_CNT; i++) begin
      if (bus_addr == ADDR_W'(A_CFG + 8 * i)) bus_rdata = cfg_q[i];
      if (bus_addr == ADDR_W'(A_VAL + 8 * i)) bus_rdata = 64'({pc_ovf_q[i], pc_val_q[i]});
    end
  end
endmodule

module dram_perf_mon_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_wdata,
  input logic              dram_rd_strobe,
  input logic              mode_q,
  input logic              active_q,
  input logic              ended_q,
  input logic              rd_en,
  input logic [CNT_W-1:0]  rd_val
);
  localparam logic [ADDR_W-1:0] C_END  = ADDR_W'(16'h8030);
  localparam logic [ADDR_W-1:0] C_FCLR = ADDR_W'(16'h80C8);

  wire rd_clear = bus_wr && bus_addr == C_FCLR && bus_wdata[1];

  assert_start_needs_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q && !active_q |=> !active_q);

  assert_end_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == C_END && bus_wdata[0] && active_q |=> !active_q && ended_q);

  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en && !rd_clear |=> $stable(rd_val));

  assert_rd_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clear && !dram_rd_strobe |=> $stable(rd_val));

  assert_clear_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clear |=> rd_val == '0);
endmodule

bind dram_perf_mon dram_perf_mon_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .dram_rd_strobe(dram_rd_strobe), .mode_q(mode_q),
  .active_q(active_q), .ended_q(ended_q), .rd_en(fr_en_q[1]), .rd_val(rd_val_q)
);

// File: tb/dram_perf_mon_bench.sv
module dram_perf_mon_bench;
  localparam int CLK_P = 10;
  localparam int CW    = 8;
  localparam int EW    = 63;
  localparam int NC    = 8;

  logic clk = 0, rst_n = 0, bus_wr = 0, rd_s = 0, wr_s = 0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0, bus_rdata;
  logic [EW-1:0] evt = '0;
  int total = 0, bad = 0;
  logic [63:0] cfg [NC];
  int exp_c [NC];
  logic [63:0] v;

  always #(CLK_P/2) clk = ~clk;

  dram_perf_mon #(.NUM_CNT(NC), .CNT_W(CW), .ADDR_W(16), .EVT_W(EW)) u_dram_perf_mon (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_lines(evt),
    .dram_rd_strobe(rd_s), .dram_wr_strobe(wr_s));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d);
    @(negedge clk); bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic drive_evt(input logic [EW-1:0] p);
    @(negedge clk); evt = p;
    for (int i = 0; i < NC; i++)
      if (cfg[i][63] && |(cfg[i][EW-1:0] & p)) exp_c[i]++;
  endtask

  task automatic strobes(input int nr, input int nw);
    for (int i = 0; i < nr || i < nw; i++) begin
      @(negedge clk); rd_s = (i < nr); wr_s = (i < nw);
    end
    @(negedge clk); rd_s = 0; wr_s = 0;
  endtask

  task automatic summary;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(16'h8020, v); chk("R1 mode", v, 0);
    rd(16'h8028, v); chk("R1 start", v, 0);
    rd(16'h8038, v); chk("R1 endst", v, 0);
    for (int i = 0; i < NC; i++) begin
      rd(16'h8040 + 16'(8*i), v); chk("R1 cfg", v, 0);
      rd(16'h8080 + 16'(8*i), v); chk("R1 val", v, 0);
    end
    rd(16'h80D0, v); chk("R1 wrval", v, 0);
    rd(16'h80D8, v); chk("R1 rdval", v, 0);
    // R10 unmapped
    rd(16'h1234, v); chk("R10 unmapped", v, 0);
    rd(16'h80E0, v); chk("R10 unmapped", v, 0);

    // R4 start ignored without manual mode
    wr(16'h8028, 1);
    rd(16'h8028, v); chk("R4 no-mode start", v, 0);

    for (int i = 0; i < NC; i++) begin cfg[i] = '0; exp_c[i] = 0; end
    cfg[0] = 64'h8000_0000_0000_0004;
    cfg[1] = (64'd1 << 63) | (64'hF << 26);
    cfg[2] = 64'h4;
    cfg[3] = (64'd1 << 63) | (64'd1 << 38);
    cfg[4] = (64'd1 << 63) | (64'd1 << 54) | 64'd1;
    for (int i = 0; i < NC; i++) wr(16'h8040 + 16'(8*i), cfg[i]);
    for (int i = 0; i < NC; i++) begin
      rd(16'h8040 + 16'(8*i), v); chk("R2 cfg readback", v, cfg[i]);
    end
    wr(16'h8020, 1);
    wr(16'h8028, 1);
    rd(16'h8028, v); chk("R4 active", v, 64'h2);

    // R2/R3 sweep
    for (int k = 0; k < EW; k++) drive_evt(EW'(64'd1 << k));
    drive_evt('1);
    drive_evt('0);
    drive_evt(EW'((64'd1 << 27) | (64'd1 << 29)));
    drive_evt(EW'((64'd1 << 54) | 64'd1));
    @(negedge clk); evt = '0;
    for (int i = 0; i < NC; i++) begin
      rd(16'h8080 + 16'(8*i), v);
      chk(i == 2 ? "R3 disarmed" : "R2 count", v, 64'(exp_c[i]));
    end

    // R5 end holds
    wr(16'h8030, 1);
    rd(16'h8038, v); chk("R5 endst", v, 1);
    rd(16'h8028, v); chk("R5 inactive", v, 0);
    repeat (5) begin @(negedge clk); evt = EW'(4); end
    @(negedge clk); evt = '0;
    rd(16'h8080, v); chk("R5 hold", v, 64'(exp_c[0]));

    // R6 restart zeroes
    wr(16'h8028, 1);
    rd(16'h8080, v); chk("R6 zero", v, 0);
    rd(16'h8038, v); chk("R6 endst clr", v, 0);

    // R7 wrap
    @(negedge clk); evt = EW'(4);
    repeat ((1 << CW) - 1) @(negedge clk);
    evt = '0;
    rd(16'h8080, v); chk("R7 max", v, 64'((1 << CW) - 1));
    @(negedge clk); evt = EW'(4);
    @(negedge clk); evt = '0;
    rd(16'h8080, v); chk("R7 wrap", v, 64'(1 << CW));
    @(negedge clk); evt = EW'(4);
    repeat (2) @(negedge clk);
    evt = '0;
    rd(16'h8080, v); chk("R7 sticky", v, 64'((1 << CW) + 2));
    wr(16'h8030, 1);
    wr(16'h8028, 1);
    rd(16'h8080, v); chk("R6 ovf clr", v, 0);
    wr(16'h8030, 1);

    // R8 dedicated counters
    wr(16'h80C0, 2);
    rd(16'h80C0, v); chk("R8 en readback", v, 2);
    strobes(5, 3);
    rd(16'h80D8, v); chk("R8 rd", v, 5);
    rd(16'h80D0, v); chk("R8 wr unarmed", v, 0);
    wr(16'h80C0, 3);
    strobes(4, 7);
    rd(16'h80D8, v); chk("R8 rd idle session", v, 9);
    rd(16'h80D0, v); chk("R8 wr", v, 7);

    // R9 clear with same-cycle strobe
    @(negedge clk); bus_wr = 1; bus_addr = 16'h80C8; bus_wdata = 2; rd_s = 1; wr_s = 1;
    @(negedge clk); bus_wr = 0; bus_wdata = 0; rd_s = 0; wr_s = 0;
    rd(16'h80D8, v); chk("R9 rd clr wins", v, 0);
    rd(16'h80D0, v); chk("R9 wr kept", v, 8);
    rd(16'h80C8, v); chk("R9 clr reads 0", v, 0);
    wr(16'h80C8, 1);
    rd(16'h80D0, v); chk("R9 wr clr", v, 0);

    // R7 dedicated wrap
    strobes(1 << CW, 0);
    rd(16'h80D8, v); chk("R7 fixed wrap", v, 64'(1 << CW));
    wr(16'h80C8, 2);
    rd(16'h80D8, v); chk("R9 ovf clr", v, 0);

    summary();
  end
endmodule